// File: doc/BRIEF.md
# Counter-Driven Accumulator Self-Check Harness

This block is a built-in tester for a bit-sliced accumulator. An up-counter makes the data stream. The same counter word goes to two accumulator instances with identical interfaces, on the same cycle. One is the device under test, built from chained one-bit ALU slices. The other is a behavioural model of the same function. A 3-bit operation select, taken from external switches, picks what both accumulators do with each incoming word.

On every step, each accumulator combines the counter word (operand A) with its own stored value (operand B) and stores the result. The harness compares the two stored values on every clock cycle and keeps a sticky failure flag. The counter walks once through every value of its width and then stops. One cycle after the last value has been applied, the harness raises the success output, unless a mismatch has been seen. A synchronous reset restarts the whole test: it clears the counter, both accumulators and both status outputs.

A parameter can place a single-bit fault in the device under test for one chosen operation. This gives a way to prove that the comparison path catches a real difference.

Top module: `acc_selfcheck_harness`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter, both accumulators, `pass_o` and `fail_o` are all cleared to zero at that edge.
- R2: After reset, the counter applies 0, 1, ..., 2^W-1 on consecutive cycles, one value per cycle. It then stops at 2^W-1, and no accumulator changes after that last value.
- R3: The operation codes are as follows, with A the counter word and B the stored value: 000 A+B, 001 A-B, 010 A&B, 011 A|B, 100 A^B, 101 ~A, 110 A, 111 zero. With no fault, the run ends in success for every code.
- R4: Any cycle in which the two stored values differ sets `fail_o` at the next rising edge.
- R5: Once set, `fail_o` stays high until reset.
- R6: With no mismatch, `pass_o` goes high exactly 2^W+1 rising edges after reset is released and stays high. It is never high while `fail_o` is high.
- R7: `pass_o` and `fail_o` are never high together. Both stay low while the counter is running and no mismatch has occurred.
- R8: With parameter FAULT_OP set to a code from 0 to 7, the device under test inverts result bit 0 for that code only. When that code is selected, `fail_o` rises on the second rising edge after reset is released and `pass_o` never rises. For the other codes the run passes.
- R9: Asserting `rst` in the middle of a run, or after it has ended, restarts the test from the beginning with the same timing as the first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high test restart |
| op_sel | input | 3 | Operation select from switches (codes in R3) |
| pass_o | output | 1 | Run finished with no mismatch |
| fail_o | output | 1 | Sticky mismatch seen since reset |

## Verification
A wrong stored value in the device under test shows up on `fail_o` two edges after the step that caused it: one edge to store the value and one to register the comparison. The fault-injected instance checks that this latency is exact. A counter that stops early or late, or a finish register that misses a cycle, moves the edge on which `pass_o` rises, so the bench checks both status outputs at every cycle of every run. It also checks that the two outputs never overlap.

// File: rtl/acc_harness_pkg.sv
package acc_harness_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOTA = 3'd5,
    OP_PASS = 3'd6,
    OP_ZERO = 3'd7
  } acc_op_e;

  // one-bit result of a slice, carry handled by caller
  function automatic logic slice_logic(input acc_op_e op, input logic a,
                                       input logic b, input logic sum);
    case (op)
      OP_ADD, OP_SUB: return sum;
      OP_AND:         return a & b;
      OP_OR:          return a | b;
      OP_XOR:         return a ^ b;
      OP_NOTA:        return ~a;
      OP_PASS:        return a;
      default:        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/stim_counter.sv
module stim_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt_o,
  output logic         step_o,
  output logic         done_o
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign step_o = !done_q;
  assign done_o = done_q;
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import acc_harness_pkg::*;
(
  input  acc_op_e op,
  input  logic    a,
  input  logic    b,
  input  logic    cin,
  output logic    r,
  output logic    cout
);
  logic b_eff;
  logic sum;

  assign b_eff = b ^ (op == OP_SUB);
  assign sum   = a ^ b_eff ^ cin;
  assign cout  = (a & b_eff) | (cin & (a ^ b_eff));
  assign r     = slice_logic(op, a, b, sum);
endmodule

// File: rtl/slice_accumulator.sv
module slice_accumulator
  import acc_harness_pkg::*;
#(
  parameter int W        = 4,
  parameter int FAULT_OP = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  acc_op_e      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_o
);
  localparam logic [3:0] FLT = 4'(FAULT_OP);

  logic [W:0]   carry;
  logic [W-1:0] res;
  logic [W-1:0] acc_q;
  logic         flip;

  assign carry[0] = (op == OP_SUB);
  assign flip     = !FLT[3] && (op == acc_op_e'(FLT[2:0]));

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu_bit_slice u_bit (
      .op  (op),
      .a   (din[i]),
      .b   (acc_q[i]),
      .cin (carry[i]),
      .r   (res[i]),
      .cout(carry[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= {res[W-1:1], res[0] ^ flip};
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/ref_accumulator.sv
module ref_accumulator
  import acc_harness_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  acc_op_e      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_o
);
  function automatic logic [W-1:0] next_val(input acc_op_e o,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    case (o)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_NOTA: return ~a;
      OP_PASS: return a;
      default: return '0;
    endcase
  endfunction

  logic [W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= next_val(op, din, acc_q);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/acc_selfcheck_harness.sv
module acc_selfcheck_harness
  import acc_harness_pkg::*;
#(
  parameter int W        = 4,
  parameter int FAULT_OP = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] op_sel,
  output logic       pass_o,
  output logic       fail_o
);
  logic [W-1:0] cnt_w;
  logic         step_w;
  logic         done_w;
  logic [W-1:0] dut_acc_w;
  logic [W-1:0] ref_acc_w;
  logic         mismatch_w;
  logic         fail_q;
  logic         fin_q;
  acc_op_e      op_w;

  assign op_w = acc_op_e'(op_sel);

  stim_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_o(cnt_w), .step_o(step_w), .done_o(done_w)
  );

  slice_accumulator #(.W(W), .FAULT_OP(FAULT_OP)) u_dut (
    .clk(clk), .rst(rst), .en(step_w), .op(op_w), .din(cnt_w), .acc_o(dut_acc_w)
  );

  ref_accumulator #(.W(W)) u_ref (
    .clk(clk), .rst(rst), .en(step_w), .op(op_w), .din(cnt_w), .acc_o(ref_acc_w)
  );

  assign mismatch_w = (dut_acc_w != ref_acc_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fail_q <= fail_q | mismatch_w;
      fin_q  <= done_w;
    end
  end

  assign fail_o = fail_q;
  assign pass_o = fin_q & ~fail_q;
endmodule

// File: rtl/acc_harness_checker.sv
module acc_harness_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cnt,
  input logic         done,
  input logic         fin,
  input logic         mism,
  input logic         pass,
  input logic         fail
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !done && !pass && !fail));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!done && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  assert_hold_last_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && cnt == LAST));

  assert_mismatch_flags_R4: assert property (@(posedge clk) disable iff (rst)
    mism |=> fail);

  assert_sticky_fail_R5: assert property (@(posedge clk) disable iff (rst)
    fail |=> fail);

  assert_pass_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    pass |-> (fin && done));

  assert_exclusive_R7: assert property (@(posedge clk)
    !(pass && fail));
endmodule

bind acc_selfcheck_harness acc_harness_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .cnt(cnt_w), .done(done_w), .fin(fin_q),
  .mism(mismatch_w), .pass(pass_o), .fail(fail_o)
);

// File: tb/acc_selfcheck_harness_tb.sv
module acc_selfcheck_harness_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int FLT        = 3;
  localparam int STEPS      = 1 << W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_sel = 3'd0;
  logic       pass_c, fail_c, pass_f, fail_f;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_selfcheck_harness #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .pass_o(pass_c), .fail_o(fail_c)
  );

  acc_selfcheck_harness #(.W(W), .FAULT_OP(FLT)) dut_f_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .pass_o(pass_f), .fail_o(fail_f)
  );

  task automatic check(input string req, input logic act, input logic exp,
                       input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d t=%0t actual=%b expected=%b",
               req, what, op_sel, $time, act, exp);
    end
  endtask

  // reset held for two edges, released at a falling edge
  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", pass_c, 1'b0, "pass after reset");
    check("R1", fail_c, 1'b0, "fail after reset");
    check("R1", fail_f, 1'b0, "faulty fail after reset");
    rst = 1'b0;
  endtask

  // after edge k (k rising edges since release) expected outputs
  task automatic run_op(input logic [2:0] op);
    bit hit;
    op_sel = op;
    do_reset();
    hit = (int'(op) == FLT);
    for (int k = 1; k <= STEPS + 4; k++) begin
      @(negedge clk);
      // clean instance: R2/R6/R7 timing
      check((k > STEPS) ? "R6" : "R7", pass_c, (k > STEPS) ? 1'b1 : 1'b0, "clean pass");
      check("R3", fail_c, 1'b0, "clean fail");
      // faulty instance: R8 latency, R5 stickiness
      check((k > 2) ? "R5" : "R8", fail_f, (hit && k >= 2) ? 1'b1 : 1'b0, "faulty fail");
      check("R8", pass_f, (!hit && k > STEPS) ? 1'b1 : 1'b0, "faulty pass");
      if (pass_f && fail_f) check("R7", 1'b1, 1'b0, "both high");
    end
  endtask

  initial begin
    for (int op = 0; op < 8; op++) run_op(3'(op));

    // R9: restart in mid-run, then rerun with identical timing
    op_sel = 3'(FLT);
    do_reset();
    repeat (7) @(posedge clk);
    @(negedge clk);
    check("R4", fail_f, 1'b1, "fault seen before restart");
    do_reset();
    @(negedge clk);
    check("R9", fail_f, 1'b0, "one edge after restart");
    @(negedge clk);
    check("R9", fail_f, 1'b1, "two edges after restart");
    op_sel = 3'd0;
    do_reset();
    repeat (STEPS - 1) @(posedge clk);
    @(negedge clk);
    check("R9", pass_c, 1'b0, "pass not yet after restart");
    @(negedge clk);
    check("R9", pass_c, 1'b0, "pass not yet at last step");
    @(negedge clk);
    check("R9", pass_c, 1'b1, "pass after restart");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule